// File: doc/BRIEF.md
# Cartridge SRAM Access Sequencer

This block sits on the host side of a battery-backed 4 KiB SRAM cartridge. The cartridge is reached only through a four-register parallel-port device: one register per address byte, one data register, and a mode register that sets the direction of the data register. The sequencer accepts one access at a time on a valid/ready request port, with a write flag, an address and write data. It then runs the fixed, ordered series of I/O bus cycles that the cartridge needs. When the series is finished it returns a one-cycle done pulse with the read byte.

The order of the I/O cycles protects the stored data. The address and data registers are loaded before the chip-enable bit goes high. A second cycle to the same register drops chip enable straight afterwards. The sequencer remembers the data-register direction it last programmed, so a run of reads or a run of writes pays for the mode-register cycle only once. The remembered direction starts as unknown after reset. A request whose address falls outside the 4 KiB window is refused with a one-cycle error pulse and causes no bus traffic.

Top module: `cart_access_seq`

## Requirements
- R1: After reset `req_ready` is 1, both strobes are 0, and `resp_valid` and `resp_err` are 0. Once a request is accepted, `req_ready` stays 0 until the clock after the `resp_valid` or `resp_err` pulse.
- R2: A read issues these cycles in this order: write 0x89 to port base+3 (only when R4 calls for it), write addr[7:0] to base+0, write 0xC0 | addr[11:8] to base+1, read base+2, write 0x80 | addr[11:8] to base+1. The default base is 0xB0.
- R3: A write issues these cycles in this order: write 0x80 to base+3 (only when R4 calls for it), write the data to base+2, write addr[7:0] to base+0, write 0x40 | addr[11:8] to base+1, write addr[11:8] to base+1.
- R4: The mode-register cycle is issued on the first access after reset and whenever the direction differs from the last one programmed. It is left out when the direction is the same. A refused request does not change the remembered direction.
- R5: Every write to base+1 carries addr[11:8] in bits 3:0 and 0 in bits 5:4. Bit 6 (chip enable) is set only in the cycle that follows the address and data loads, and the next base+1 write clears it.
- R6: Bits 7 (output enable) and 6 (chip enable) of base+1 are never set together while the mode register holds 0x80 (data register driving).
- R7: Each bus cycle raises exactly one of `io_rd`/`io_wr` for `STROBE_CLKS` clocks. `io_addr` and `io_wdata` stay constant during the strobe, and the strobes are low for at least one clock between cycles.
- R8: Read data is taken from `io_rdata` on the last clock of the base+2 read strobe. It is presented on `resp_rdata` with a `resp_valid` pulse that lasts one clock.
- R9: A request with address 0x1000 or above gives a one-clock `resp_err` pulse, with no `resp_valid` and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 8 | Byte to store |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_err | output | 1 | One-clock refusal pulse for an out-of-range address |
| resp_rdata | output | 8 | Byte read, valid with resp_valid |
| io_addr | output | 8 | I/O port address |
| io_wdata | output | 8 | I/O write data |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data |

## Verification
The hardest condition to reach from the ports is a read byte that is valid only on the last clock of the read strobe. A bench device that returns correct data for the whole strobe would hide a capture taken on the wrong clock. The bench therefore models the port device and the SRAM together. Its model returns filler on every strobe clock except the last, and read-back only matches if the capture is on that clock. Direction changes are driven by alternating reads and writes. Refused requests are placed between accesses of the same kind, which shows whether a refusal disturbed the remembered direction.

// File: rtl/cart_seq_pkg.sv
package cart_seq_pkg;
  localparam int IO_W = 8;

  typedef enum logic [1:0] {
    DIR_UNK = 2'd0,
    DIR_IN  = 2'd1,
    DIR_OUT = 2'd2
  } port_dir_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_WAIT  = 3'd2,
    S_DONE  = 3'd3,
    S_ERR   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic            is_rd;
    logic [IO_W-1:0] port;
    logic [IO_W-1:0] data;
  } io_op_t;
endpackage

// File: rtl/cart_seq_steps.sv
module cart_seq_steps
  import cart_seq_pkg::*;
#(
  parameter logic [7:0] PORT_BASE = 8'hB0,
  parameter int         HI_W      = 4
) (
  input  logic            op_write,
  input  logic [2:0]      step,
  input  logic [7:0]      addr_lo,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [7:0]      wdata,
  output io_op_t          op
);
  localparam logic [7:0] P_LO   = PORT_BASE;
  localparam logic [7:0] P_HI   = PORT_BASE + 8'd1;
  localparam logic [7:0] P_DATA = PORT_BASE + 8'd2;
  localparam logic [7:0] P_MODE = PORT_BASE + 8'd3;
  localparam logic [7:0] MODE_OUT = 8'h80;
  localparam logic [7:0] MODE_IN  = 8'h89;
  localparam logic [7:0] B_CE   = 8'h40;
  localparam logic [7:0] B_OE   = 8'h80;

  logic [7:0] hi_ext;
  assign hi_ext = {{(8-HI_W){1'b0}}, addr_hi};

  always_comb begin
    op = '0;
    if (op_write) begin
      case (step)
        3'd0:    begin op.port = P_MODE; op.data = MODE_OUT; end
        3'd1:    begin op.port = P_DATA; op.data = wdata; end
        3'd2:    begin op.port = P_LO;   op.data = addr_lo; end
        3'd3:    begin op.port = P_HI;   op.data = B_CE | hi_ext; end
        default: begin op.port = P_HI;   op.data = hi_ext; end
      endcase
    end else begin
      case (step)
        3'd0:    begin op.port = P_MODE; op.data = MODE_IN; end
        3'd1:    begin op.port = P_LO;   op.data = addr_lo; end
        3'd2:    begin op.port = P_HI;   op.data = B_OE | B_CE | hi_ext; end
        3'd3:    begin op.port = P_DATA; op.is_rd = 1'b1; end
        default: begin op.port = P_HI;   op.data = B_OE | hi_ext; end
      endcase
    end
  end
endmodule

// File: rtl/cart_seq_io_cycle.sv
module cart_seq_io_cycle
  import cart_seq_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  io_op_t          op,
  input  logic [IO_W-1:0] io_rdata,
  output logic [IO_W-1:0] io_addr,
  output logic [IO_W-1:0] io_wdata,
  output logic            io_rd,
  output logic            io_wr,
  output logic            fin,
  output logic [IO_W-1:0] cap
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      io_addr  <= '0;
      io_wdata <= '0;
      io_rd    <= 1'b0;
      io_wr    <= 1'b0;
      fin      <= 1'b0;
      cap      <= '0;
    end else begin
      fin <= 1'b0;
      if (active) begin
        if (cnt == LAST) begin
          if (io_rd) cap <= io_rdata;
          io_rd  <= 1'b0;
          io_wr  <= 1'b0;
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        io_addr  <= op.port;
        io_wdata <= op.data;
        io_rd    <= op.is_rd;
        io_wr    <= ~op.is_rd;
        cnt      <= '0;
        active   <= 1'b1;
      end
    end
  end

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));
  p_hold_bus_r7: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && $past(io_rd || io_wr)) |-> ($stable(io_addr) && $stable(io_wdata)));
  p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !(io_rd || io_wr));
  p_fin_gap_r7: assert property (@(posedge clk) disable iff (rst)
    fin |-> !(io_rd || io_wr));
endmodule

// File: rtl/cart_access_seq.sv
module cart_access_seq
  import cart_seq_pkg::*;
#(
  parameter int         REQ_AW      = 16,
  parameter int         CART_AW     = 12,
  parameter int         STROBE_CLKS = 2,
  parameter logic [7:0] PORT_BASE   = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [7:0]        resp_rdata,
  output logic [7:0]        io_addr,
  output logic [7:0]        io_wdata,
  output logic              io_rd,
  output logic              io_wr,
  input  logic [7:0]        io_rdata
);
  localparam int         HI_W      = CART_AW - 8;
  localparam logic [2:0] LAST_STEP = 3'd4;

  seq_state_e      st;
  port_dir_e       dir_q;
  logic            op_wr;
  logic [7:0]      a_lo;
  logic [HI_W-1:0] a_hi;
  logic [7:0]      wd;
  logic [2:0]      step;
  io_op_t          cur_op;
  logic            fin;
  logic [7:0]      cap;
  logic            accept;
  logic            out_of_range;
  port_dir_e       req_dir;
  port_dir_e       op_dir;

  assign accept       = req_valid && req_ready;
  assign out_of_range = |req_addr[REQ_AW-1:CART_AW];
  assign req_dir      = req_write ? DIR_OUT : DIR_IN;
  assign op_dir       = op_wr ? DIR_OUT : DIR_IN;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      dir_q      <= DIR_UNK;
      req_ready  <= 1'b1;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
      op_wr      <= 1'b0;
      a_lo       <= '0;
      a_hi       <= '0;
      wd         <= '0;
      step       <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            if (out_of_range) begin
              resp_err <= 1'b1;
              st       <= S_ERR;
            end else begin
              op_wr <= req_write;
              a_lo  <= req_addr[7:0];
              a_hi  <= req_addr[CART_AW-1:8];
              wd    <= req_wdata;
              step  <= (dir_q == req_dir) ? 3'd1 : 3'd0;
              st    <= S_ISSUE;
            end
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (fin) begin
            if (step == 3'd0) dir_q <= op_dir;
            if (step == LAST_STEP) begin
              resp_valid <= 1'b1;
              resp_rdata <= cap;
              st         <= S_DONE;
            end else begin
              step <= step + 3'd1;
              st   <= S_ISSUE;
            end
          end
        end
        S_DONE: begin
          resp_valid <= 1'b0;
          req_ready  <= 1'b1;
          st         <= S_IDLE;
        end
        default: begin
          resp_err  <= 1'b0;
          req_ready <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  cart_seq_steps #(.PORT_BASE(PORT_BASE), .HI_W(HI_W)) u_steps (
    .op_write (op_wr),
    .step     (step),
    .addr_lo  (a_lo),
    .addr_hi  (a_hi),
    .wdata    (wd),
    .op       (cur_op)
  );

  cart_seq_io_cycle #(.STROBE_CLKS(STROBE_CLKS)) u_cycle (
    .clk      (clk),
    .rst      (rst),
    .start    (st == S_ISSUE),
    .op       (cur_op),
    .io_rdata (io_rdata),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .fin      (fin),
    .cap      (cap)
  );

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> !req_ready);
  p_done_not_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (resp_valid || resp_err) |-> !req_ready);
  p_hi_bits_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == PORT_BASE + 8'd1) |-> (io_wdata[5:4] == 2'b00));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == PORT_BASE + 8'd1 && io_wdata[7] && io_wdata[6]) |-> (dir_q == DIR_IN));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (!io_rd && !io_wr && !resp_valid));
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_err |=> !resp_err);
endmodule

// File: tb/tb_cart_access_seq.sv
`timescale 1ns/1ps
module tb_cart_access_seq;
  localparam int SC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        resp_valid, resp_err;
  logic [7:0]  resp_rdata;
  logic [7:0]  io_addr, io_wdata, io_rdata;
  logic        io_rd, io_wr;

  cart_access_seq #(.STROBE_CLKS(SC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Port device plus SRAM model
  logic [7:0] ppa, ppb, ppc, mode;
  logic [7:0] mem [0:4095];
  logic [7:0] shadow [0:4095];
  int  rd_k;
  logic prev_stb;
  int  stb_w;
  int  ln;
  logic [7:0] lp [0:63];
  logic [7:0] ld [0:63];
  logic       lr [0:63];
  int  viol_r6, viol_r5, viol_r7;

  always @(posedge clk) begin
    if (rst) begin
      ppa <= 0; ppb <= 0; ppc <= 0; mode <= 0;
    end else begin
      if (io_wr && !prev_stb) begin
        case (io_addr)
          8'hB0: ppa <= io_wdata;
          8'hB1: ppb <= io_wdata;
          8'hB2: ppc <= io_wdata;
          8'hB3: begin mode <= io_wdata; ppa <= 0; ppb <= 0; ppc <= 0; end
          default: ;
        endcase
      end
      if (mode == 8'h80 && ppb[6] && !ppb[7]) mem[{ppb[3:0], ppa}] <= ppc;
    end
  end

  always @(posedge clk) rd_k <= io_rd ? rd_k + 1 : 0;

  assign io_rdata = (io_rd && rd_k == SC - 1 && mode == 8'h89 && ppb[6] && ppb[7])
                    ? mem[{ppb[3:0], ppa}] : 8'hEE;

  initial begin ln = 0; stb_w = 0; prev_stb = 0; viol_r5 = 0; viol_r6 = 0; viol_r7 = 0; end

  always @(posedge clk) begin
    if (!rst) begin
      prev_stb <= io_rd || io_wr;
      if ((io_rd || io_wr) && !prev_stb) begin
        lp[ln % 64] <= io_addr;
        ld[ln % 64] <= io_wdata;
        lr[ln % 64] <= io_rd;
        ln <= ln + 1;
      end
      if (io_rd || io_wr) stb_w <= stb_w + 1;
      else begin
        if (prev_stb && stb_w != SC) viol_r7 <= viol_r7 + 1;
        stb_w <= 0;
      end
      if (io_rd && io_wr) viol_r7 <= viol_r7 + 1;
      if (mode == 8'h80 && ppb[7] && ppb[6]) viol_r6 <= viol_r6 + 1;
      if (io_wr && io_addr == 8'hB1 && io_wdata[5:4] != 2'b00) viol_r5 <= viol_r5 + 1;
    end
  end

  int bench_dir = 0; // 0 unknown, 1 read, 2 write

  task automatic access(input bit wr, input int addr, input logic [7:0] d);
    int base;
    int n;
    logic [7:0] ep [0:4];
    logic [7:0] ed [0:4];
    logic       er [0:4];
    logic [7:0] hi;
    bit bad;
    bit ok;
    int want;
    logic [7:0] got;
    bad  = (addr >= 4096);
    hi   = 8'((addr >> 8) & 15);
    want = wr ? 2 : 1;
    n = 0;
    if (!bad) begin
      if (bench_dir != want) begin
        ep[n] = 8'hB3; ed[n] = wr ? 8'h80 : 8'h89; er[n] = 0; n++;
      end
      if (wr) begin
        ep[n] = 8'hB2; ed[n] = d;            er[n] = 0; n++;
        ep[n] = 8'hB0; ed[n] = 8'(addr);     er[n] = 0; n++;
        ep[n] = 8'hB1; ed[n] = 8'h40 | hi;   er[n] = 0; n++;
        ep[n] = 8'hB1; ed[n] = hi;           er[n] = 0; n++;
      end else begin
        ep[n] = 8'hB0; ed[n] = 8'(addr);     er[n] = 0; n++;
        ep[n] = 8'hB1; ed[n] = 8'hC0 | hi;   er[n] = 0; n++;
        ep[n] = 8'hB2; ed[n] = 8'h00;        er[n] = 1; n++;
        ep[n] = 8'hB1; ed[n] = 8'h80 | hi;   er[n] = 0; n++;
      end
    end
    while (!req_ready) @(negedge clk);
    base = ln;
    req_valid = 1'b1; req_write = wr; req_addr = 16'(addr); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready after accept", int'(req_ready), 0);
    while (!resp_valid && !resp_err) @(negedge clk);
    got = resp_rdata;
    if (bad) begin
      chk(resp_err && !resp_valid, "R9", "refusal pulse", int'(resp_err), 1);
    end else begin
      chk(resp_valid && !resp_err, "R8", "done pulse", int'(resp_valid), 1);
      if (!wr) chk(got == shadow[addr], "R8", "read data", int'(got), int'(shadow[addr]));
    end
    @(negedge clk);
    chk(!resp_valid && !resp_err && req_ready, "R1", "pulse ends, ready back",
        int'({resp_valid, resp_err, req_ready}), 1);
    if (bad) repeat (3) @(negedge clk);
    ok = (ln - base == n);
    for (int i = 0; i < n && ok; i++) begin
      if (lp[(base + i) % 64] != ep[i] || lr[(base + i) % 64] != er[i]) ok = 0;
      if (!er[i] && ld[(base + i) % 64] != ed[i]) ok = 0;
    end
    if (bad) chk(ok, "R9", "no bus cycle on refusal", ln - base, 0);
    else     chk(ok, wr ? "R3/R4/R5" : "R2/R4/R5", "cycle order", ln - base, n);
    if (!bad) begin
      bench_dir = want;
      if (wr) shadow[addr] = d;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !io_rd && !io_wr && !resp_valid && !resp_err, "R1", "reset state",
        int'({req_ready, io_rd, io_wr, resp_valid, resp_err}), 5'b10000);
    // Write sweep: first access must program the mode register (R4)
    for (int a = 0; a < 4096; a += 5) access(1, a, 8'((a * 37 + (a >> 4)) ^ 8'h5A));
    for (int a = 0; a < 4096; a += 5) access(0, a, 8'h00);
    // Alternating directions: every access programs the mode register (R4)
    for (int k = 0; k < 64; k++) begin
      int a;
      a = (k * 613 + 11) % 4096;
      access(1, a, 8'(~(k * 29)));
      access(0, a, 8'h00);
    end
    // Refusals (R9) must not disturb the remembered read direction (R4)
    access(1, 16'h1000, 8'hAA);
    access(0, 16'hFFFF, 8'h00);
    access(1, 16'h8123, 8'h55);
    access(0, 4095, 8'h00);
    access(0, 0, 8'h00);
    access(1, 4095, 8'h3C);
    access(0, 4095, 8'h00);
    chk(viol_r5 == 0, "R5", "port B bits 5:4", viol_r5, 0);
    chk(viol_r6 == 0, "R6", "enable contention", viol_r6, 0);
    chk(viol_r7 == 0, "R7", "strobe shape", viol_r7, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule